// File: doc/BRIEF.md
# Frame-Event Interrupt Controller

This block turns raster-phase strobes from a display timing generator into a single level-sensitive processor interrupt. The timing generator supplies one strobe per raster phase (back porch, vertical sync, active video start, front porch). Two independent selector fields in a control register each name one phase that counts as a frame event. The second selector can also be switched off. A rising edge on any selected phase sets a pending flag in a status register.

Software owns the block through a small register port: a control register at address 0 and a status register at address 1. The pending flag is cleared by writing one to its bit. The interrupt line is asserted only while the pending flag, a master enable and a frame-interrupt enable are all set. Masking hides the interrupt but does not stop events from being recorded, so software can poll the status register with the line disabled.

Top module: `frame_irq_ctrl`

## Requirements
- R1: During and after a synchronous reset, the control register reads 0, the pending flag is 0 and `irq_o` is 0.
- R2: A write to address 0 stores the control fields: bit 0 master enable, bit 1 frame enable, bits 3:2 selector A, bits 5:4 selector B. Reading address 0 returns them, with the upper bits zero.
- R3: Selector A codes are 0 = back porch, 1 = vertical sync, 2 = active start and 3 = front porch. The strobe bits are indexed the same way (bit 0 back porch, bit 1 vertical sync, bit 2 active start, bit 3 front porch). A rising edge on the chosen phase sets pending on that clock edge. Edges on phases that neither selector names have no effect.
- R4: Selector B code 0 disables it. Codes 1 to 3 pick vertical sync, active start or front porch, as for selector A.
- R5: Pending is set by a rising edge only. A strobe held high sets pending once, and it does not set pending again after pending is cleared while the strobe stays high.
- R6: Pending is recorded even when either enable is 0.
- R7: `irq_o` is a register. It equals pending AND master enable AND frame enable as they stood one clock earlier.
- R8: Writing 1 to bit 0 at address 1 clears pending. Writing 0 there leaves pending unchanged. Reading address 1 returns pending in bit 0, with the other bits zero.
- R9: If a clearing write and a selected rising edge land on the same clock edge, pending stays set.
- R10: Clearing both enables drops `irq_o` while pending stays set. Enabling both again raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data, valid one clock after rd_addr |
| phase_strobe | input | NUM_PHASES | Raster-phase strobes, indexed by the selector code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench steps through a table of selector settings and strobe patterns. This shows that each code of both selectors picks exactly its own phase. It also shows that selector B at code 0 stays silent and that a masked event still reaches the status register. An event routed to the wrong phase, or selector B decoding code 0 as back porch, would set pending where the table expects it clear. A strobe held across a clear must not set pending again, which a level-triggered design would get wrong. A clearing write on the same edge as an event must leave pending set, which a design giving the clear priority would lose. Writes of zero to the status register and the removal of both enables are checked to change only what they should.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned BIT_MEN   = 0;
  localparam int unsigned BIT_FEN   = 1;
  localparam int unsigned SEL_LSB   = 2;
  localparam int unsigned STAT_PEND = 0;
endpackage

// File: rtl/frame_edge_detect.sv
module frame_edge_detect #(
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] strobe,
  output logic [NUM_PHASES-1:0] rise
);
  logic [NUM_PHASES-1:0] strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= '0;
    else     strobe_q <= strobe;
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_edge
    assign rise[i] = strobe[i] & ~strobe_q[i];
    // R5: an edge lasts a single cycle even if the strobe stays high
    a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/frame_event_select.sv
module frame_event_select #(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned SEL_W      = 2
) (
  input  logic [NUM_PHASES-1:0] rise,
  input  logic [SEL_W-1:0]      sel_a,
  input  logic [SEL_W-1:0]      sel_b,
  output logic                  hit
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a = rise[sel_a];
    hit_b = (sel_b != '0) ? rise[sel_b] : 1'b0;
    hit   = hit_a | hit_b;
  end
endmodule

// File: rtl/frame_irq_regs.sv
module frame_irq_regs
  import frame_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hit,
  output logic [CTRL_W-1:0] ctrl,
  output logic              pending,
  output logic [DATA_W-1:0] rd_data
);
  logic ctrl_wr, clr_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign clr_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && wr_data[STAT_PEND];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      pending <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ctrl_wr) ctrl <= wr_data[CTRL_W-1:0];
      if (hit)         pending <= 1'b1;
      else if (clr_wr) pending <= 1'b0;
      if (rd_addr == ADDR_W'(ADDR_CTRL)) rd_data <= DATA_W'(ctrl);
      else                               rd_data <= DATA_W'(pending);
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!pending && ctrl == '0));
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !hit) |=> !pending);
  a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
    hit |=> pending);
  a_r6_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr_wr) |=> (pending == $past(pending)));
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned ADDR_W     = 1,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_PHASES-1:0] phase_strobe,
  output logic                  irq_o
);
  localparam int unsigned SEL_W  = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
  localparam int unsigned SELB_L = SEL_LSB + SEL_W;
  localparam int unsigned CTRL_W = SELB_L + SEL_W;

  logic [NUM_PHASES-1:0] rise;
  logic [CTRL_W-1:0]     ctrl;
  logic                  pending, hit, men, fen;

  frame_edge_detect #(.NUM_PHASES(NUM_PHASES)) u_edge (
    .clk(clk), .rst(rst), .strobe(phase_strobe), .rise(rise)
  );

  frame_event_select #(.NUM_PHASES(NUM_PHASES), .SEL_W(SEL_W)) u_sel (
    .rise(rise),
    .sel_a(ctrl[SEL_LSB +: SEL_W]),
    .sel_b(ctrl[SELB_L +: SEL_W]),
    .hit(hit)
  );

  frame_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .hit(hit), .ctrl(ctrl), .pending(pending), .rd_data(rd_data)
  );

  assign men = ctrl[BIT_MEN];
  assign fen = ctrl[BIT_FEN];

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending & men & fen;
  end

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(pending && men && fen));
  a_r10_enables_silence: assert property (@(posedge clk) disable iff (rst)
    !(men || fen) |=> !irq_o);
endmodule

// File: tb/frame_irq_ctrl_tb.sv
module frame_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [0:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] phase_strobe = '0;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frame_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .phase_strobe(phase_strobe), .irq_o(irq_o)
  );

  // {ctrl[5:0], strobes[3:0], expected pending, expected irq}
  // ctrl: bit0 master, bit1 frame, [3:2] selector A, [5:4] selector B
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {6'h07, 4'b0010, 1'b1, 1'b1},  // R3 A=vsync
    {6'h07, 4'b0001, 1'b0, 1'b0},  // R3 other phase ignored
    {6'h03, 4'b0001, 1'b1, 1'b1},  // R3 A=back porch
    {6'h0B, 4'b0100, 1'b1, 1'b1},  // R3 A=active
    {6'h0F, 4'b1000, 1'b1, 1'b1},  // R3 A=front porch
    {6'h0F, 4'b0111, 1'b0, 1'b0},  // R3 unselected phases
    {6'h07, 4'b1000, 1'b0, 1'b0},  // R4 B=none
    {6'h37, 4'b1000, 1'b1, 1'b1},  // R4 B=front porch
    {6'h23, 4'b0100, 1'b1, 1'b1},  // R4 B=active
    {6'h1F, 4'b0010, 1'b1, 1'b1},  // R4 B=vsync
    {6'h06, 4'b0010, 1'b1, 1'b0},  // R6 master off
    {6'h05, 4'b0010, 1'b1, 1'b0},  // R6 frame off
    {6'h04, 4'b0010, 1'b1, 1'b0}   // R6 R7 both off
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] s);
    phase_strobe = s;
    @(negedge clk);
    phase_strobe = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    rst = 1'b0;
    rd(1'b0, d); check("R1 ctrl", d, 8'h00);
    rd(1'b1, d); check("R1 pending", d, 8'h00);

    // R2 readback
    wr(1'b0, 8'hFF);
    rd(1'b0, d); check("R2 ctrl readback", d, 8'h3F);
    wr(1'b0, 8'h00);

    // R3 R4 R6 R7 table
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, {2'b00, VEC[i][11:6]});
      wr(1'b1, 8'h01);
      pulse(VEC[i][5:2]);
      rd(1'b1, d);
      check($sformatf("R3/R4/R6 vec %0d pending", i), d, {7'd0, VEC[i][1]});
      check($sformatf("R7 vec %0d irq", i), {7'd0, irq_o}, {7'd0, VEC[i][0]});
    end

    // R8: write zero keeps pending, write one clears
    wr(1'b0, 8'h07);
    pulse(4'b0010);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R8 write zero keeps", d, 8'h01);
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R8 write one clears", d, 8'h00);
    check("R8 irq after clear", {7'd0, irq_o}, 8'd0);

    // R9 clear and event on the same edge
    phase_strobe = 4'b0010;
    wr(1'b1, 8'h01);
    phase_strobe = '0;
    rd(1'b1, d); check("R9 event wins", d, 8'h01);

    // R10 enables off silence, back on restore
    @(negedge clk);
    check("R10 irq before", {7'd0, irq_o}, 8'd1);
    wr(1'b0, 8'h04);
    @(negedge clk);
    check("R10 irq silenced", {7'd0, irq_o}, 8'd0);
    rd(1'b1, d); check("R10 pending kept", d, 8'h01);
    wr(1'b0, 8'h07);
    @(negedge clk);
    check("R10 irq restored", {7'd0, irq_o}, 8'd1);

    // R5 held strobe: clear while held does not re-set
    wr(1'b1, 8'h01);
    phase_strobe = 4'b0010;
    @(negedge clk);
    rd(1'b1, d); check("R5 held sets once", d, 8'h01);
    wr(1'b1, 8'h01);
    repeat (3) @(negedge clk);
    rd(1'b1, d); check("R5 held no re-set", d, 8'h00);
    phase_strobe = '0;
    @(negedge clk);
    pulse(4'b0010);
    rd(1'b1, d); check("R5 new edge sets", d, 8'h01);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(1'b1, d); check("R1 pending after reset", d, 8'h00);
    check("R1 irq after reset", {7'd0, irq_o}, 8'd0);

    finish_run();
  end
endmodule